// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block sits next to an 8-bit processor core. It decides which interrupt the core takes next and supplies the address of that interrupt's vector. It collects level request flags from six on-chip peripherals and a strobe for the non-maskable software trap. It also watches two groups of port pins that can act as external interrupt inputs. Each pin group has its own sensitivity setting: falling edge, rising edge, both edges, or low level.

The core acknowledges at an instruction boundary. At that acknowledge the block picks the highest-ranked eligible source and latches its vector. The vector then stays unchanged until the next acknowledge. If the chosen source is an edge-latched external group, the block clears that group's latch and sends out a one-cycle auto-clear pulse. Maskable sources are gated by the core's global mask bit and by their own enable bits. The software trap ignores the mask. Setting the mask on entry and clearing it on return is done by the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and right after synchronous reset, `vector` reads FFFEh, `ext_autoclr` is 0 and `irq` is 0 while nothing is pending.
- R2: At an acknowledge, the highest-ranked eligible source wins. Rank and vector, from high to low: trap FFFCh, external group 0 FFF8h, external group 1 FFF6h, `periph_req[0]` FFF4h, `periph_req[1]` FFF2h, `periph_req[2]` FFF0h, `periph_req[3]` FFEEh, `periph_req[4]` FFECh, `periph_req[5]` FFEAh. The bits of `src_en` follow the same order: bit 0 is group 0, bit 1 is group 1, and bits 2 to 7 are `periph_req[0]` to `periph_req[5]`.
- R3: A maskable source raises `irq` only when `core_mask` is 0 and its `src_en` bit is 1. Otherwise its request stays pending and comes back once it is enabled again.
- R4: A `trap_strobe` pulse is latched and raises `irq` even when `core_mask` is 1. At an acknowledge the trap outranks every other source, and its latch clears once it is taken.
- R5: `vector` changes only at an acknowledge that occurs while `irq` is 1. An acknowledge with `irq` at 0 leaves it unchanged.
- R6: The 2-bit group sensitivity code selects 00 falling edge, 01 rising edge, 10 both edges, or 11 low level. In low-level mode the request follows the pins directly and is not latched.
- R7: Within a group, the pins whose select bit is 1 are ANDed before edge or level detection. A low selected pin therefore blocks a rising edge on another pin, while pins whose select bit is 0 are ignored.
- R8: Taking an edge-mode group clears its latch at the acknowledge. The matching `ext_autoclr` bit (bit 0 for group 0) is then 1 for exactly the following cycle. A level-mode group gives no pulse.
- R9: An `ext_clr` bit discards that group's pending edge latch, even while the group is disabled.
- R10: Arbitration happens only at an acknowledge. A request that arrives after an acknowledge does not change `vector` until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grp0_pins | input | GRP0_W | External group 0 pin levels |
| grp0_sel | input | GRP0_W | Group 0 pins configured as interrupt inputs |
| grp0_sense | input | 2 | Group 0 sensitivity code |
| grp1_pins | input | GRP1_W | External group 1 pin levels |
| grp1_sel | input | GRP1_W | Group 1 pins configured as interrupt inputs |
| grp1_sense | input | 2 | Group 1 sensitivity code |
| ext_clr | input | 2 | Per-group discard of the pending edge latch |
| periph_req | input | 6 | Peripheral request flags |
| src_en | input | 8 | Per-source enable bits |
| core_mask | input | 1 | Core global interrupt mask |
| trap_strobe | input | 1 | Software trap request pulse |
| ack | input | 1 | Core acknowledge at instruction boundary |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 16 | Vector address of the last granted source |
| ext_autoclr | output | 2 | One-cycle auto-clear pulse per external group |

## Verification
The hardest case to reach from the ports is the AND masking inside a pin group. A rising edge must be blocked while another selected pin is low, yet it must still register when only an unselected pin is low. The stimulus first pulls two selected pins low in rising-edge mode and then releases them one at a time, checking `irq` after each step. It then removes one pin from the selection and repeats the sequence with that pin held low. Discarding a pending request is reached by latching an edge while the group is disabled, pulsing `ext_clr`, and then enabling the group to show that nothing is left.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_EXT    = 2;
    localparam int N_PERIPH = 6;
    localparam int N_MASK   = N_EXT + N_PERIPH;
    localparam int VEC_W    = 16;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;

    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_BOTH = 2'b10,
        SENSE_LOW  = 2'b11
    } sense_e;

    // Rank order: smaller encoding wins.
    typedef enum logic [3:0] {
        SRC_RESET  = 4'd0,
        SRC_TRAP   = 4'd1,
        SRC_EXT0   = 4'd2,
        SRC_EXT1   = 4'd3,
        SRC_MC_A   = 4'd4,
        SRC_MC_B   = 4'd5,
        SRC_MC_C   = 4'd6,
        SRC_SERIAL = 4'd7,
        SRC_TIM_A  = 4'd8,
        SRC_TIM_B  = 4'd9,
        SRC_NONE   = 4'd15
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } grant_t;

    // Reset and trap occupy the two top slots; one slot is skipped below trap.
    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        logic [VEC_W-1:0] off;
        off = {11'b0, s, 1'b0};
        case (s)
            SRC_RESET, SRC_TRAP: vec_of = VEC_TOP - off;
            default:             vec_of = VEC_TOP - off - 16'd2;
        endcase
    endfunction

endpackage

// File: rtl/ext_detect.sv
module ext_detect
    import irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] sel,
    input  sense_e       sense,
    input  logic         clr,
    input  logic         take,
    output logic         pend,
    output logic         level_mode
);

    logic combined;
    logic prev_q;
    logic latch_q;
    logic rise, fall, event_hit;

    // Unselected pins read as high so they never pull the AND down.
    assign combined   = &(pins | ~sel);
    assign rise       = combined & ~prev_q;
    assign fall       = ~combined & prev_q;
    assign level_mode = (sense == SENSE_LOW);

    always_comb begin
        case (sense)
            SENSE_FALL: event_hit = fall;
            SENSE_RISE: event_hit = rise;
            SENSE_BOTH: event_hit = rise | fall;
            default:    event_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= combined;
            if (level_mode)
                latch_q <= 1'b0;
            else
                latch_q <= (latch_q & ~clr & ~take) | event_hit;
        end
    end

    assign pend = level_mode ? ~combined : latch_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N = N_MASK
) (
    input  logic         trap,
    input  logic [N-1:0] elig,
    output grant_t       grant
);

    always_comb begin
        grant.valid = 1'b0;
        grant.src   = SRC_NONE;
        if (trap) begin
            grant.valid = 1'b1;
            grant.src   = SRC_TRAP;
        end else begin
            // Walk from lowest rank upward so the highest rank is written last.
            for (int i = N - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    grant.valid = 1'b1;
                    grant.src   = src_e'(4'(i) + 4'(SRC_EXT0));
                end
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int GRP0_W = 8,
    parameter int GRP1_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GRP0_W-1:0]   grp0_pins,
    input  logic [GRP0_W-1:0]   grp0_sel,
    input  logic [1:0]          grp0_sense,
    input  logic [GRP1_W-1:0]   grp1_pins,
    input  logic [GRP1_W-1:0]   grp1_sel,
    input  logic [1:0]          grp1_sense,
    input  logic [N_EXT-1:0]    ext_clr,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic [N_MASK-1:0]   src_en,
    input  logic                core_mask,
    input  logic                trap_strobe,
    input  logic                ack,
    output logic                irq,
    output logic [VEC_W-1:0]    vector,
    output logic [N_EXT-1:0]    ext_autoclr
);

    logic [N_EXT-1:0]  ext_pend;
    logic [N_EXT-1:0]  ext_level;
    logic [N_EXT-1:0]  take_ext;
    logic [N_MASK-1:0] pend_all;
    logic [N_MASK-1:0] elig;
    logic              trap_q;
    logic              take;
    grant_t            grant;
    logic [VEC_W-1:0]  vector_q;
    logic [N_EXT-1:0]  autoclr_q;

    ext_detect #(.W(GRP0_W)) u_ext0 (
        .clk        (clk),
        .rst        (rst),
        .pins       (grp0_pins),
        .sel        (grp0_sel),
        .sense      (sense_e'(grp0_sense)),
        .clr        (ext_clr[0]),
        .take       (take_ext[0]),
        .pend       (ext_pend[0]),
        .level_mode (ext_level[0])
    );

    ext_detect #(.W(GRP1_W)) u_ext1 (
        .clk        (clk),
        .rst        (rst),
        .pins       (grp1_pins),
        .sel        (grp1_sel),
        .sense      (sense_e'(grp1_sense)),
        .clr        (ext_clr[1]),
        .take       (take_ext[1]),
        .pend       (ext_pend[1]),
        .level_mode (ext_level[1])
    );

    assign pend_all = {periph_req, ext_pend};
    assign elig     = pend_all & src_en & {N_MASK{~core_mask}};

    irq_arbiter #(.N(N_MASK)) u_arb (
        .trap  (trap_q),
        .elig  (elig),
        .grant (grant)
    );

    assign irq  = grant.valid;
    assign take = ack & grant.valid;

    always_comb begin
        for (int g = 0; g < N_EXT; g++)
            take_ext[g] = take && (grant.src == src_e'(4'(g) + 4'(SRC_EXT0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q    <= 1'b0;
            vector_q  <= VEC_TOP;
            autoclr_q <= '0;
        end else begin
            trap_q    <= trap_strobe | (trap_q & ~(take && grant.src == SRC_TRAP));
            autoclr_q <= take_ext & ~ext_level;
            if (take)
                vector_q <= vec_of(grant.src);
        end
    end

    assign vector      = vector_q;
    assign ext_autoclr = autoclr_q;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic [15:0] vector,
    input logic [1:0]  ext_autoclr,
    input logic        ack,
    input logic        core_mask,
    input logic        trap_strobe,
    input logic        trap_q
);

    // R3: masked core sees nothing but the trap
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (core_mask && !trap_q) |-> !irq);

    // R4: a trap strobe always produces a request next cycle
    a_r4_trap_raises: assert property (@(posedge clk) disable iff (rst)
        trap_strobe |=> irq);

    // R5: vector moves only after an acknowledge
    a_r5_vec_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(ack) |-> $stable(vector));

    // R8: auto-clear follows an acknowledge, one group at a time
    a_r8_autoclr_after_ack: assert property (@(posedge clk) disable iff (rst)
        (ext_autoclr != 2'b00) |-> $past(ack));

    a_r8_autoclr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_autoclr));

    // R2: auto-clear pulse agrees with the vector just granted
    a_r2_grp0_vec: assert property (@(posedge clk) disable iff (rst)
        ext_autoclr[0] |-> (vector == 16'hFFF8));

    a_r2_grp1_vec: assert property (@(posedge clk) disable iff (rst)
        ext_autoclr[1] |-> (vector == 16'hFFF6));

endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .vector      (vector),
    .ext_autoclr (ext_autoclr),
    .ack         (ack),
    .core_mask   (core_mask),
    .trap_strobe (trap_strobe),
    .trap_q      (trap_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  grp0_pins, grp0_sel;
    logic [1:0]  grp0_sense;
    logic [5:0]  grp1_pins, grp1_sel;
    logic [1:0]  grp1_sense;
    logic [1:0]  ext_clr;
    logic [5:0]  periph_req;
    logic [7:0]  src_en;
    logic        core_mask, trap_strobe, ack;
    logic        irq;
    logic [15:0] vector;
    logic [1:0]  ext_autoclr;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst(rst),
        .grp0_pins(grp0_pins), .grp0_sel(grp0_sel), .grp0_sense(grp0_sense),
        .grp1_pins(grp1_pins), .grp1_sel(grp1_sel), .grp1_sense(grp1_sense),
        .ext_clr(ext_clr), .periph_req(periph_req), .src_en(src_en),
        .core_mask(core_mask), .trap_strobe(trap_strobe), .ack(ack),
        .irq(irq), .vector(vector), .ext_autoclr(ext_autoclr)
    );

    typedef struct packed {
        logic        mask;
        logic [7:0]  en;
        logic [5:0]  req;
        logic        exp_irq;
        logic [15:0] exp_vec;
    } row_t;

    localparam row_t TBL [0:7] = '{
        '{1'b0, 8'hFF, 6'h3F, 1'b1, 16'hFFF4},
        '{1'b0, 8'hFC, 6'h30, 1'b1, 16'hFFEC},
        '{1'b0, 8'hFC, 6'h20, 1'b1, 16'hFFEA},
        '{1'b0, 8'hFF, 6'h08, 1'b1, 16'hFFEE},
        '{1'b1, 8'hFF, 6'h3F, 1'b0, 16'hFFEE},
        '{1'b0, 8'h00, 6'h3F, 1'b0, 16'hFFEE},
        '{1'b0, 8'h80, 6'h3F, 1'b1, 16'hFFEA},
        '{1'b0, 8'h10, 6'h06, 1'b1, 16'hFFF0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        grp0_pins = 8'hFF; grp0_sel = 8'h00; grp0_sense = 2'b00;
        grp1_pins = 6'h3F; grp1_sel = 6'h00; grp1_sense = 2'b00;
        ext_clr = 2'b00; periph_req = 6'h00; src_en = 8'h00;
        core_mask = 1'b0; trap_strobe = 1'b0; ack = 1'b0;
        repeat (3) tick();
        check("R1 vector in reset", vector, 16'hFFFE);
        rst = 1'b0;
        tick();
        check("R1 vector", vector, 16'hFFFE);
        check("R1 irq", irq, 0);
        check("R1 autoclr", ext_autoclr, 0);

        // Table walk: R3 gating and R2/R5 vector choice
        for (int k = 0; k < 8; k++) begin
            core_mask  = TBL[k].mask;
            src_en     = TBL[k].en;
            periph_req = TBL[k].req;
            tick();
            check("R3 irq gating", irq, TBL[k].exp_irq);
            pulse_ack();
            check("R2 vector", vector, TBL[k].exp_vec);
        end
        periph_req = 6'h00; src_en = 8'hFF; core_mask = 1'b0;
        tick();

        // R4: trap bypasses mask and outranks everything
        core_mask = 1'b1; periph_req = 6'h3F; trap_strobe = 1'b1;
        tick();
        trap_strobe = 1'b0;
        check("R4 trap irq while masked", irq, 1);
        pulse_ack();
        check("R4 trap vector", vector, 16'hFFFC);
        check("R4 trap cleared", irq, 0);
        core_mask = 1'b0; trap_strobe = 1'b1;
        tick();
        trap_strobe = 1'b0;
        pulse_ack();
        check("R4 trap wins", vector, 16'hFFFC);
        periph_req = 6'h00;
        tick();

        // R10: late arrival does not move the vector
        periph_req = 6'h20;
        tick();
        pulse_ack();
        check("R10 first grant", vector, 16'hFFEA);
        periph_req = 6'h21;
        repeat (3) tick();
        check("R10 vector held", vector, 16'hFFEA);
        pulse_ack();
        check("R10 next grant", vector, 16'hFFF4);
        periph_req = 6'h00;
        tick();

        // R7 and R6: AND of selected pins in rising mode
        grp0_sel = 8'h83; grp0_sense = 2'b01;
        tick();
        grp0_pins = 8'hFC;
        tick();
        check("R6 fall ignored in rise mode", irq, 0);
        grp0_pins = 8'hFE;
        tick();
        check("R7 low pin blocks rise", irq, 0);
        grp0_pins = 8'hFF;
        tick();
        check("R6 rise latched", irq, 1);
        pulse_ack();
        check("R2 group0 vector", vector, 16'hFFF8);
        check("R8 autoclr pulse", ext_autoclr, 2'b01);
        tick();
        check("R8 pulse one cycle", ext_autoclr, 2'b00);
        check("R8 latch cleared", irq, 0);

        grp0_sel = 8'h03;
        tick();
        grp0_pins = 8'h7F;
        tick();
        check("R7 unselected pin no event", irq, 0);
        grp0_pins = 8'h7C;
        tick();
        grp0_pins = 8'h7F;
        tick();
        check("R7 unselected low ignored", irq, 1);
        pulse_ack();
        grp0_pins = 8'hFF;
        tick();

        // R6 level mode
        grp0_sense = 2'b11;
        grp0_pins = 8'hFE;
        tick();
        check("R6 level irq", irq, 1);
        pulse_ack();
        check("R6 level vector", vector, 16'hFFF8);
        check("R8 no pulse in level mode", ext_autoclr, 2'b00);
        check("R6 level persists", irq, 1);
        grp0_pins = 8'hFF;
        tick();
        check("R6 level released", irq, 0);

        // R6 both edges
        grp0_sense = 2'b10;
        tick();
        grp0_pins = 8'hFE;
        tick();
        check("R6 both: fall", irq, 1);
        pulse_ack();
        tick();
        grp0_pins = 8'hFF;
        tick();
        check("R6 both: rise", irq, 1);
        pulse_ack();
        check("R6 both vector", vector, 16'hFFF8);

        // R3 and R9 on group 1
        grp1_sel = 6'h01; grp1_sense = 2'b00; src_en = 8'hFD;
        tick();
        grp1_pins = 6'h3E;
        tick();
        check("R3 disabled group silent", irq, 0);
        src_en = 8'hFF;
        tick();
        check("R3 pending kept", irq, 1);
        src_en = 8'hFD; ext_clr = 2'b10;
        tick();
        ext_clr = 2'b00; src_en = 8'hFF;
        tick();
        check("R9 pending discarded", irq, 0);
        grp1_pins = 6'h3F;
        tick();

        // R2: group0 > group1 > peripherals
        grp0_sense = 2'b00;
        grp0_pins = 8'hFE; grp1_pins = 6'h3E; periph_req = 6'h01;
        tick();
        pulse_ack();
        check("R2 group0 first", vector, 16'hFFF8);
        pulse_ack();
        check("R2 group1 second", vector, 16'hFFF6);
        check("R8 group1 pulse", ext_autoclr, 2'b10);
        pulse_ack();
        check("R2 periph third", vector, 16'hFFF4);
        periph_req = 6'h00;
        tick();
        check("R5 idle", irq, 0);
        pulse_ack();
        check("R5 ack without irq", vector, 16'hFFF4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule